// File: doc/BRIEF.md
# Dual-Mode Serial Clock Rate Generator

This block turns a fast module clock into the timing for a serial shift engine. It reads one control word that holds two divider fields and a mode bit. In linear mode the serial clock period is an even multiple of the module clock. In exponential mode the period is a power of two. The generator does not output a free-running clock. It outputs a registered serial clock level plus single-cycle strobes: one on every toggle, one on each edge that leaves the idle level (leading), and one on each edge that returns to it (trailing). A neighbouring shift register uses these strobes to launch and sample bits. A frame strobe marks the last edge of every frame.

The transfer engine raises `run` to start a transfer and holds it high for as long as clocking should continue. When `run` drops, clocking stops at once and the serial clock returns to the level given by `cpol`. The divider setting is captured only while the block is idle, so rewriting the control word during a transfer is harmless. There is no data stream through this block, so every pin is a plain control or status pin with no valid/ready handshake.

Top module: `sck_rate_gen`

## Requirements
- R1: When bit 12 of `clk_cfg` is 1 (linear mode), the toggle strobe fires every N+1 module clock cycles. N is the unsigned value of `clk_cfg[7:0]`, so one serial clock period is 2*(N+1) cycles.
- R2: When bit 12 of `clk_cfg` is 0 (exponential mode), the toggle strobe fires every 2^M module clock cycles. M is `clk_cfg[11:8]`, so one serial clock period is 2^(M+1) cycles.
- R3: Linear mode with `clk_cfg[7:0]` = 0 fires a toggle strobe on every cycle while running, so the serial clock runs at half the module clock.
- R4: While `run` is low, `sck` equals `cpol` and no toggle, leading, trailing or frame strobe fires.
- R5: The first toggle strobe of a transfer comes a full half-period after the start. If the start edge is the first clock edge that samples `run` high, the first strobe is visible in the cycle that follows that edge by the half-period count.
- R6: A change to `clk_cfg` while a transfer runs does not change the strobe spacing of that transfer. The new setting applies from the next start.
- R7: Strobes alternate: the first, third, fifth (and so on) strobes of a transfer are leading strobes, and the rest are trailing strobes. A leading strobe moves `sck` away from `cpol`.
- R8: Each frame of FRAME_BITS bits (default 8) has exactly 2*FRAME_BITS toggle strobes. `frame_end` fires together with the last strobe of each frame, and frames repeat while `run` stays high.
- R9: `sck` changes only in the cycle after a toggle strobe and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Transfer active; a rising level starts a transfer |
| cpol | input | 1 | Idle level of the serial clock |
| clk_cfg | input | 13 | [7:0] linear divider, [11:8] exponential divider, [12] mode select (1 = linear) |
| sck | output | 1 | Serial clock level |
| sck_toggle | output | 1 | One-cycle strobe: `sck` toggles at the next edge |
| lead_edge | output | 1 | Toggle strobe that leaves the idle level |
| trail_edge | output | 1 | Toggle strobe that returns to the idle level |
| frame_end | output | 1 | Strobe that comes with the last toggle of a frame |

## Verification
The hardest case to reach is a divider rewrite in the middle of a transfer. A strobe-spacing error would only show up many cycles after the write, and only if the new setting differs from the running one. The stimulus starts a slow linear transfer and then, a few cycles in, switches the word to exponential mode with a different period. It checks that every later strobe keeps the old spacing. It then starts a second transfer that must use the new period. Random settings with both polarities add to this, together with directed extremes: the fastest rate, the widest linear field, and a transfer that runs two frames.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
  localparam int LIN_W   = 8;                       // linear divider field width
  localparam int EXP_W   = 4;                       // exponential divider field width
  localparam int SEL_BIT = LIN_W + EXP_W;           // mode select position
  localparam int CFG_W   = SEL_BIT + 1;             // control word width
  localparam int HALF_W  = ((LIN_W + 1) > (1 << EXP_W)) ? (LIN_W + 1) : (1 << EXP_W);

  // Half-period length, in module clock cycles, for a control word.
  function automatic logic [HALF_W-1:0] half_len(input logic [CFG_W-1:0] w);
    if (w[SEL_BIT])
      return HALF_W'(w[LIN_W-1:0]) + HALF_W'(1);
    else
      return HALF_W'(1) << w[SEL_BIT-1:LIN_W];
  endfunction
endpackage

// File: rtl/sckdiv_cfg.sv
module sckdiv_cfg
  import sckdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [CFG_W-1:0]  clk_cfg,
  output logic [HALF_W-1:0] half_now
);
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] half_in;

  assign half_in = half_len(clk_cfg);

  // Capture only while idle; frozen for the length of a transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    half_q <= HALF_W'(1);
    else if (!busy) half_q <= half_in;
  end

  assign half_now = busy ? half_q : half_in;
endmodule

// File: rtl/sckdiv_tick.sv
module sckdiv_tick
  import sckdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_now,
  output logic              busy,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      busy <= run;
      cnt  <= half_now - HALF_W'(1);   // reload: first half-period is full
    end else if (!run) begin
      busy <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= half_now - HALF_W'(1);
    end else begin
      cnt  <= cnt - HALF_W'(1);
    end
  end

  assign tick = busy & run & (cnt == '0);
endmodule

// File: rtl/sckdiv_edge.sv
module sckdiv_edge #(
  parameter int FRAME_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cpol,
  input  logic tick,
  output logic sck,
  output logic lead,
  output logic trail,
  output logic frame_end
);
  localparam int EDGES = 2 * FRAME_BITS;
  localparam int EC_W  = (EDGES > 1) ? $clog2(EDGES) : 1;

  logic            phase;   // 0 = at idle level
  logic [EC_W-1:0] ec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      ec    <= '0;
    end else if (!run) begin
      phase <= 1'b0;
      ec    <= '0;
    end else if (tick) begin
      phase <= ~phase;
      ec    <= (ec == EC_W'(EDGES - 1)) ? '0 : ec + EC_W'(1);
    end
  end

  assign sck       = cpol ^ (phase & run);
  assign lead      = tick & ~phase;
  assign trail     = tick & phase;
  assign frame_end = tick & (ec == EC_W'(EDGES - 1));
endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
  import sckdiv_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cpol,
  input  logic [CFG_W-1:0] clk_cfg,
  output logic             sck,
  output logic             sck_toggle,
  output logic             lead_edge,
  output logic             trail_edge,
  output logic             frame_end
);
  logic              busy;
  logic              tick;
  logic [HALF_W-1:0] half_now;

  sckdiv_cfg i_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy), .clk_cfg(clk_cfg), .half_now(half_now)
  );

  sckdiv_tick i_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .half_now(half_now), .busy(busy), .tick(tick)
  );

  sckdiv_edge #(.FRAME_BITS(FRAME_BITS)) i_edge (
    .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .tick(tick),
    .sck(sck), .lead(lead_edge), .trail(trail_edge), .frame_end(frame_end)
  );

  assign sck_toggle = tick;
endmodule

// File: rtl/sck_rate_gen_chk.sv
module sck_rate_gen_chk
  import sckdiv_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cpol,
  input logic [CFG_W-1:0] clk_cfg,
  input logic             sck,
  input logic             sck_toggle,
  input logic             lead_edge,
  input logic             trail_edge,
  input logic             frame_end
);
  localparam int EDGES = 2 * FRAME_BITS;
  localparam int TC_W  = (EDGES > 1) ? $clog2(EDGES) : 1;

  logic              prev_run, st;
  logic [HALF_W:0]   gap;
  logic [HALF_W-1:0] half_ck;
  logic [TC_W-1:0]   tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_run <= 1'b0;
      st       <= 1'b0;
      gap      <= '0;
      half_ck  <= '0;
      tc       <= '0;
    end else begin
      prev_run <= run;
      if (run && !prev_run) begin
        st      <= 1'b1;
        gap     <= (HALF_W+1)'(1);
        half_ck <= half_len(clk_cfg);
        tc      <= '0;
      end else if (run) begin
        gap <= sck_toggle ? (HALF_W+1)'(1) : gap + (HALF_W+1)'(1);
        if (sck_toggle) tc <= (tc == TC_W'(EDGES - 1)) ? '0 : tc + TC_W'(1);
      end
    end
  end

  // R5 (also R1, R2): each strobe lands exactly one half-period after the last one or after the start
  a_r5_full_half: assert property (@(posedge clk) disable iff (!rst_n)
    (run && prev_run && st && sck_toggle) |-> (gap == {1'b0, half_ck}));

  // R6: the spacing never stretches past the value captured at start
  a_r6_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (run && prev_run && st) |-> (gap <= {1'b0, half_ck}));

  // R4: idle means idle level and no strobes
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sck == cpol && !sck_toggle && !lead_edge && !trail_edge && !frame_end));

  // R7: a leading strobe moves the clock away from idle
  a_r7_lead_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_edge && run && sck == cpol) |=> (!run || !$stable(cpol) || sck != cpol));

  // R8: frame strobe only on the last toggle of a frame
  a_r8_frame_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (sck_toggle && tc == TC_W'(EDGES - 1)));

  // R9: no toggle strobe, no change of level
  a_r9_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(sck_toggle) && $stable(cpol)) |-> $stable(sck));
endmodule

bind sck_rate_gen sck_rate_gen_chk #(.FRAME_BITS(FRAME_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .clk_cfg(clk_cfg),
  .sck(sck), .sck_toggle(sck_toggle), .lead_edge(lead_edge),
  .trail_edge(trail_edge), .frame_end(frame_end)
);

// File: tb/test_sck_rate_gen.sv
module test_sck_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cpol = 1'b0;
  logic [12:0] clk_cfg = 13'h1000;
  logic        sck, sck_toggle, lead_edge, trail_edge, frame_end;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;   // 125 MHz

  sck_rate_gen i_sck_rate_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .clk_cfg(clk_cfg),
    .sck(sck), .sck_toggle(sck_toggle), .lead_edge(lead_edge),
    .trail_edge(trail_edge), .frame_end(frame_end)
  );

  function automatic int exp_half(input logic [12:0] w);
    if (w[12]) return int'(w[7:0]) + 1;
    return 1 << w[11:8];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      if (nfail <= 20) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_check(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R4 idle sck", int'(sck), int'(cpol));
      chk("R4 idle strobes", int'({sck_toggle, lead_edge, trail_edge, frame_end}), 0);
    end
  endtask

  // Start a transfer from a negedge; optionally rewrite the word at sample chg_at.
  task automatic run_xfer(input logic [12:0] w, input logic cp, input int frames,
                          input int chg_at, input logic [12:0] w2);
    int h, total, n;
    string rtag;
    h = exp_half(w);
    total = frames * 16 * h;
    rtag = (chg_at > 0) ? "R6" : (w[12] ? ((w[7:0] == 8'd0) ? "R3" : "R1") : "R2");
    clk_cfg = w;
    cpol = cp;
    run = 1'b1;
    for (int s = 1; s <= total; s++) begin
      @(negedge clk);
      chk((s == h) ? "R5 first strobe" : rtag, int'(sck_toggle), int'(s % h == 0));
      chk("R9 sck level", int'(sck), int'(cp) ^ (((s - 1) / h) % 2));
      if (s % h == 0) begin
        n = s / h;
        chk("R7 lead", int'(lead_edge), int'(n % 2 == 1));
        chk("R7 trail", int'(trail_edge), int'(n % 2 == 0));
        chk("R8 frame_end", int'(frame_end), int'(n % 16 == 0));
      end else begin
        chk("R8 no frame_end", int'(frame_end), 0);
      end
      if (s == chg_at) clk_cfg = w2;
    end
    run = 1'b0;
    #1;
    chk("R4 drop sck", int'(sck), int'(cp));
    chk("R4 drop strobe", int'(sck_toggle), 0);
    idle_check(3);
  endtask

  initial begin
    #(8 * 200000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [12:0] w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R4 reset sck", int'(sck), 0);
    chk("R4 reset strobes", int'({sck_toggle, lead_edge, trail_edge, frame_end}), 0);
    rst_n = 1'b1;
    idle_check(2);

    // R4: config churn while idle produces nothing
    clk_cfg = 13'h0300;
    cpol = 1'b1;
    idle_check(4);

    run_xfer(13'h1000, 1'b0, 2, 0, 13'h0);   // R3 fastest, two frames
    run_xfer(13'h10FF, 1'b0, 1, 0, 13'h0);   // R1 widest linear
    run_xfer(13'h0000, 1'b1, 1, 0, 13'h0);   // R2 M=0
    run_xfer(13'h0300, 1'b0, 1, 0, 13'h0);   // R2 M=3
    run_xfer(13'h1004, 1'b1, 1, 0, 13'h0);   // R1 with cpol=1
    run_xfer(13'h1002, 1'b0, 1, 10, 13'h0500);  // R6 mid-transfer rewrite
    run_xfer(13'h0500, 1'b0, 1, 0, 13'h0);   // R6 new value at next start

    for (int k = 0; k < 10; k++) begin
      w = 13'($urandom);
      if (!w[12]) w[11:8] = 4'($urandom % 7);
      run_xfer(w, 1'($urandom), 1, 0, 13'h0);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule